// File: doc/BRIEF.md
# Multiplexed Address/Data External Bus Master

This block runs external memory cycles for a small 8-bit controller system in which the low address byte and the data byte travel on one shared bidirectional port. The separate high port carries the upper address byte. An internal client raises a request with a cycle kind, a 16-bit address and, for writes, a data byte. The block then steps through four phases: address, latch, strobe and recovery. It drives an address-latch strobe, three active-low access strobes and the shared port. For reads it returns the byte with a one-clock done pulse.

In the address phase the latch strobe is high while the low address byte sits on the shared port. The latch strobe falls while that byte is still driven, so an external transparent latch holds it. The port then turns around. For reads it is released. For writes it carries the data. Exactly one access strobe goes low, and which one depends on the cycle kind. Each phase length is a parameter, and every phase defaults to two clocks.

Top module: `mxb_bus_master`

## Requirements
- R1: While reset is asserted, the three access strobes are high, the latch strobe is low, busy and done are low and the shared port is not driven.
- R2: A cycle begins with ADDR_CLKS clocks of latch strobe high. During them the shared port carries address bits 7:0 and the high port carries address bits 15:8.
- R3: In the first clock after the latch strobe falls, the shared port still carries address bits 7:0.
- R4: Kind 2'b00 (program fetch) drives the strobe triple {program-store, read, write} to 0,1,1 for STROBE_CLKS clocks.
- R5: Kind 2'b01 (data read) drives the triple to 1,0,1. Kind 2'b11 is treated as a data read.
- R6: Kind 2'b10 (data write) drives the triple to 1,1,0.
- R7: For fetches and reads, the byte on the shared port in the last strobe clock is captured as the strobe rises. That byte is presented on rdata_o when done is high.
- R8: The high port holds address bits 15:8 from the first address clock to the end of the cycle.
- R9: For fetches and reads, the shared port is released from the second latch-phase clock through the end of the cycle.
- R10: For writes, the data byte is on the shared port from the second latch-phase clock, before the write strobe falls. It stays there through the recovery phase, after the strobe rises.
- R11: A request is accepted only while busy is low. Requests raised during a cycle, including in its done clock, are ignored.
- R12: busy is high from the clock after acceptance until done. done is a single pulse in the last recovery clock, so a cycle lasts ADDR_CLKS+LATCH_CLKS+STROBE_CLKS+RECOV_CLKS clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Cycle request, sampled while idle |
| kind_i | input | 2 | Cycle kind: 00 fetch, 01 read, 10 write, 11 read |
| addr_i | input | 16 | Cycle address |
| wdata_i | input | 8 | Write data |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-clock end-of-cycle pulse |
| rdata_o | output | 8 | Byte captured by the last fetch or read |
| ale_o | output | 1 | Address latch strobe, active high |
| pstore_n_o | output | 1 | Program-store strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |
| addr_hi_o | output | 8 | High address byte |
| ad_io | inout | 8 | Shared low-address/data port |

## Verification
Fetches are run at addresses 0000, 7FFF, 8000, FFFF and A5C3, whose two bytes differ. A byte swap or a stale latch value therefore shows on the port and in the returned data. Writes are followed by reads and fetches of the same address. The external model keeps program and data spaces apart, so a strobe that is wrong or merged returns the wrong byte. A read with kind 2'b11 checks the fallback encoding. A client that keeps requesting a different address for the whole cycle checks that requests are ignored while busy and that no extra cycle follows done. During turnaround the bench drives a marker byte on the port to prove that the block has let go of it.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ADDR   = 3'd1,
    PH_LATCH  = 3'd2,
    PH_STROBE = 3'd3,
    PH_RECOV  = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    K_FETCH = 2'b00,
    K_READ  = 2'b01,
    K_WRITE = 2'b10,
    K_READX = 2'b11
  } kind_e;

  function automatic logic kind_writes(kind_e k);
    return k == K_WRITE;
  endfunction

endpackage

// File: rtl/mxb_rst_sync.sv
module mxb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/mxb_phase_timer.sv
module mxb_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] len,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)  cnt_d = '0;
    else if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == len - 1'b1);

  // counter never runs past the current phase length (supports R12)
  assert_cnt_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= len - 1'b1));
endmodule

// File: rtl/mxb_strobe_gen.sv
module mxb_strobe_gen
  import mxb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  active,
  input  kind_e kind,
  output logic  pstore_n,
  output logic  rd_n,
  output logic  wr_n
);
  always_comb begin
    pstore_n = 1'b1;
    rd_n     = 1'b1;
    wr_n     = 1'b1;
    if (active) begin
      unique case (kind)
        K_FETCH:         pstore_n = 1'b0;
        K_WRITE:         wr_n     = 1'b0;
        K_READ, K_READX: rd_n     = 1'b0;
        default:         rd_n     = 1'b0;
      endcase
    end
  end

  // at most one access strobe low at any time (R4, R5, R6)
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~pstore_n, ~rd_n, ~wr_n}) <= 1);
  assert_strobe_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (kind == K_WRITE));
endmodule

// File: rtl/mxb_port_ctl.sv
module mxb_port_ctl
  import mxb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  phase_e            phase,
  input  logic              first_clk,
  input  logic              is_write,
  input  logic [DATA_W-1:0] addr_lo,
  input  logic [DATA_W-1:0] wdata,
  output logic              oe,
  output logic [DATA_W-1:0] out
);
  logic addr_slot;
  logic data_slot;

  always_comb begin
    addr_slot = (phase == PH_ADDR) || (phase == PH_LATCH && first_clk);
    data_slot = is_write &&
                ((phase == PH_LATCH && !first_clk) ||
                 phase == PH_STROBE || phase == PH_RECOV);
    oe  = addr_slot || data_slot;
    out = addr_slot ? addr_lo : wdata;
  end
endmodule

// File: rtl/mxb_bus_master.sv
module mxb_bus_master
  import mxb_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int ADDR_CLKS   = 2,
  parameter int LATCH_CLKS  = 2,
  parameter int STROBE_CLKS = 2,
  parameter int RECOV_CLKS  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_i,
  input  logic [1:0]           kind_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 ale_o,
  output logic                 pstore_n_o,
  output logic                 rd_n_o,
  output logic                 wr_n_o,
  output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
  inout  wire  [DATA_W-1:0]    ad_io
);
  localparam int HI_W     = ADDR_W - DATA_W;
  localparam int LATCH_EF = (LATCH_CLKS < 2) ? 2 : LATCH_CLKS;
  localparam int MAX_A    = (ADDR_CLKS > LATCH_EF) ? ADDR_CLKS : LATCH_EF;
  localparam int MAX_B    = (STROBE_CLKS > RECOV_CLKS) ? STROBE_CLKS : RECOV_CLKS;
  localparam int MAX_LEN  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_LEN + 1);

  logic srst_n;
  mxb_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  phase_e            ph_q, ph_d;
  kind_e             kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [CNT_W-1:0]  len, cnt;
  logic              last, accept, is_write, sample_en;
  logic              port_oe;
  logic [DATA_W-1:0] port_out;

  // phase length select
  always_comb begin
    unique case (ph_q)
      PH_ADDR:   len = CNT_W'(ADDR_CLKS);
      PH_LATCH:  len = CNT_W'(LATCH_EF);
      PH_STROBE: len = CNT_W'(STROBE_CLKS);
      PH_RECOV:  len = CNT_W'(RECOV_CLKS);
      default:   len = CNT_W'(1);
    endcase
  end

  mxb_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(srst_n),
    .run(ph_q != PH_IDLE), .restart(ph_d != ph_q),
    .len(len), .cnt_o(cnt), .last_o(last)
  );

  assign accept = (ph_q == PH_IDLE) && req_i;

  // next phase
  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:   if (accept) ph_d = PH_ADDR;
      PH_ADDR:   if (last)   ph_d = PH_LATCH;
      PH_LATCH:  if (last)   ph_d = PH_STROBE;
      PH_STROBE: if (last)   ph_d = PH_RECOV;
      PH_RECOV:  if (last)   ph_d = PH_IDLE;
      default:               ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) ph_q <= PH_IDLE;
    else         ph_q <= ph_d;
  end

  // request capture, enabled on acceptance only
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      kind_q  <= K_FETCH;
    end else if (accept) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      kind_q  <= kind_e'(kind_i);
    end
  end

  assign is_write  = kind_writes(kind_q);
  assign sample_en = (ph_q == PH_STROBE) && last && !is_write;

  // read capture on the edge where the strobe rises
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)        rdata_q <= '0;
    else if (sample_en) rdata_q <= ad_io;
  end

  mxb_strobe_gen u_strb (
    .clk(clk), .rst_n(srst_n),
    .active(ph_q == PH_STROBE), .kind(kind_q),
    .pstore_n(pstore_n_o), .rd_n(rd_n_o), .wr_n(wr_n_o)
  );

  mxb_port_ctl #(.DATA_W(DATA_W)) u_port (
    .phase(ph_q), .first_clk(cnt == '0), .is_write(is_write),
    .addr_lo(addr_q[DATA_W-1:0]), .wdata(wdata_q),
    .oe(port_oe), .out(port_out)
  );

  assign ad_io     = port_oe ? port_out : {DATA_W{1'bz}};
  assign ale_o     = (ph_q == PH_ADDR);
  assign addr_hi_o = addr_q[ADDR_W-1:DATA_W];
  assign busy_o    = (ph_q != PH_IDLE);
  assign done_o    = (ph_q == PH_RECOV) && last;
  assign rdata_o   = rdata_q;

  // ---------------- assertions ----------------
  assert_ale_addr_R2: assert property (@(posedge clk) disable iff (!srst_n)
    ale_o |-> (port_oe && port_out == addr_q[DATA_W-1:0]));
  assert_ale_hold_R3: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(ale_o) |-> (port_oe && port_out == addr_q[DATA_W-1:0]));
  assert_hi_hold_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (busy_o && !done_o) |=> $stable(addr_hi_o));
  assert_read_release_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (!pstore_n_o || !rd_n_o) |-> !port_oe);
  assert_write_drive_R10: assert property (@(posedge clk) disable iff (!srst_n)
    (!wr_n_o) |-> (port_oe && port_out == wdata_q));
  assert_write_hold_R10: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(wr_n_o) |-> port_oe);
  assert_accept_idle_R11: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(busy_o) |-> $past(req_i));
  assert_capture_hold_R11: assert property (@(posedge clk) disable iff (!srst_n)
    busy_o |=> $stable(addr_q));
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!srst_n)
    done_o |=> (!done_o && !busy_o));
  assert_done_busy_R12: assert property (@(posedge clk) disable iff (!srst_n)
    done_o |-> busy_o);
endmodule

// File: tb/mxb_bus_master_test.sv
module mxb_bus_master_test;
  import mxb_pkg::*;

  typedef struct {
    logic [1:0]  kind;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic [7:0]  rexp;
  } item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic req;
  logic [1:0] kind;
  logic [15:0] addr;
  logic [7:0] wdata;
  logic busy_o, done_o, ale_o, pstore_n_o, rd_n_o, wr_n_o;
  logic [7:0] rdata_o, addr_hi_o;
  wire  [7:0] ad;

  int total = 0;
  int bad = 0;
  int k = 0;
  item_t q[$];
  item_t cur;
  logic [7:0] shadow [logic [15:0]];
  logic [7:0] dmem [logic [15:0]];
  logic [7:0] lat;
  logic       probe_en;
  logic [7:0] mem_val;
  logic       mem_en;

  always #2 clk = ~clk;

  mxb_bus_master uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .kind_i(kind), .addr_i(addr),
    .wdata_i(wdata), .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
    .ale_o(ale_o), .pstore_n_o(pstore_n_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
    .addr_hi_o(addr_hi_o), .ad_io(ad)
  );

  function automatic logic [7:0] pfun(logic [15:0] a);
    return {a[3:0], a[15:12]} ^ a[11:4] ^ 8'h96;
  endfunction
  function automatic logic [7:0] dflt(logic [15:0] a);
    return a[7:0] ^ ~a[15:8];
  endfunction

  // external address latch and memory model
  always @(ale_o or ad) if (ale_o) lat = ad;
  assign mem_en = !pstore_n_o || !rd_n_o;
  always @(pstore_n_o or rd_n_o or lat or addr_hi_o) begin
    if (!pstore_n_o) mem_val = pfun({addr_hi_o, lat});
    else if (dmem.exists({addr_hi_o, lat})) mem_val = dmem[{addr_hi_o, lat}];
    else mem_val = dflt({addr_hi_o, lat});
  end
  assign ad = probe_en ? 8'h3C : (mem_en ? mem_val : 8'hzz);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (busy_o) begin
        if (k == 0) begin
          if (q.size() == 0) chk(0, "R11 unexpected cycle", 1, 0);
          else cur = q[0];
        end
        k++;
        chk(addr_hi_o == cur.addr[15:8], "R8 high port", addr_hi_o, cur.addr[15:8]);
        case (k)
          1, 2: chk(ale_o && ad == cur.addr[7:0], "R2 address phase",
                    {ale_o, ad}, {1'b1, cur.addr[7:0]});
          3: begin
            chk(!ale_o && ad == cur.addr[7:0], "R3 latch hold",
                {ale_o, ad}, {1'b0, cur.addr[7:0]});
            if (cur.kind != 2'b10) probe_en <= 1'b1;
          end
          4: begin
            chk({pstore_n_o, rd_n_o, wr_n_o} == 3'b111, "R4 strobes idle in latch",
                {pstore_n_o, rd_n_o, wr_n_o}, 3'b111);
            if (cur.kind == 2'b10) chk(ad == cur.wd, "R10 data before strobe", ad, cur.wd);
            else                   chk(ad == 8'h3C, "R9 port released", ad, 8'h3C);
            probe_en <= 1'b0;
          end
          5, 6: begin
            case (cur.kind)
              2'b00: chk({pstore_n_o, rd_n_o, wr_n_o} == 3'b011, "R4 fetch strobes",
                         {pstore_n_o, rd_n_o, wr_n_o}, 3'b011);
              2'b10: chk({pstore_n_o, rd_n_o, wr_n_o} == 3'b110, "R6 write strobes",
                         {pstore_n_o, rd_n_o, wr_n_o}, 3'b110);
              default: chk({pstore_n_o, rd_n_o, wr_n_o} == 3'b101, "R5 read strobes",
                           {pstore_n_o, rd_n_o, wr_n_o}, 3'b101);
            endcase
            if (cur.kind == 2'b10) begin
              chk(ad == cur.wd, "R10 data during strobe", ad, cur.wd);
              if (k == 6) dmem[{addr_hi_o, lat}] = ad;
            end
          end
          7: begin
            chk({pstore_n_o, rd_n_o, wr_n_o} == 3'b111, "R12 recovery strobes high",
                {pstore_n_o, rd_n_o, wr_n_o}, 3'b111);
            if (cur.kind == 2'b10) chk(ad == cur.wd, "R10 data hold", ad, cur.wd);
          end
          8: ;
          default: chk(0, "R12 cycle too long", k, 8);
        endcase
        chk(done_o == (k == 8), "R12 done timing", done_o, (k == 8));
        if (done_o) begin
          if (cur.kind != 2'b10)
            chk(rdata_o == cur.rexp, "R7 read data", rdata_o, cur.rexp);
          if (q.size() != 0) void'(q.pop_front());
          k = 0;
        end
      end else begin
        if (k != 0) begin
          chk(0, "R12 cycle too short", k, 8);
          k = 0;
        end
        if (done_o) chk(0, "R12 done while idle", 1, 0);
      end
    end
  end

  task automatic issue(input logic [1:0] kd, input logic [15:0] a,
                       input logic [7:0] d, input bit hog);
    item_t it;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    it.kind = kd; it.addr = a; it.wd = d;
    if (kd == 2'b00) it.rexp = pfun(a);
    else if (kd == 2'b10) begin it.rexp = 8'h00; shadow[a] = d; end
    else it.rexp = shadow.exists(a) ? shadow[a] : dflt(a);
    q.push_back(it);
    req = 1'b1; kind = kd; addr = a; wdata = d;
    @(negedge clk);
    if (hog) begin
      kind = 2'b10; addr = ~a; wdata = ~d;
      while (!done_o) @(negedge clk);
    end
    req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; kind = 2'b00; addr = 16'h0; wdata = 8'h0;
    probe_en = 1'b1;
    repeat (3) @(negedge clk);
    chk({pstore_n_o, rd_n_o, wr_n_o} == 3'b111 && !ale_o, "R1 reset strobes",
        {pstore_n_o, rd_n_o, wr_n_o, ale_o}, 4'b1110);
    chk(!busy_o && !done_o, "R1 reset busy/done", {busy_o, done_o}, 2'b00);
    chk(ad == 8'h3C, "R1 reset port released", ad, 8'h3C);
    probe_en = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // fetches across address corners (R2, R4, R7, R8)
    issue(2'b00, 16'h0000, 8'h00, 0);
    issue(2'b00, 16'h7FFF, 8'h00, 0);
    issue(2'b00, 16'h8000, 8'h00, 0);
    issue(2'b00, 16'hFFFF, 8'h00, 0);
    issue(2'b00, 16'hA5C3, 8'h00, 0);
    // data reads of unwritten locations (R5, R9)
    issue(2'b01, 16'h1281, 8'h00, 0);
    issue(2'b11, 16'h4C42, 8'h00, 0);
    // writes then read-back and same-address fetch (R6, R10)
    issue(2'b10, 16'h8123, 8'h5E, 0);
    issue(2'b10, 16'h0042, 8'hA1, 0);
    issue(2'b01, 16'h8123, 8'h00, 0);
    issue(2'b11, 16'h0042, 8'h00, 0);
    issue(2'b00, 16'h8123, 8'h00, 0);
    // request held through a whole cycle (R11)
    issue(2'b01, 16'h3C81, 8'h00, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!busy_o, "R11 no cycle from ignored request", busy_o, 0);
    end
    issue(2'b10, 16'hF00D, 8'h77, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!busy_o, "R11 no cycle from ignored request", busy_o, 0);
    end
    issue(2'b01, 16'hF00D, 8'h00, 0);
    // back-to-back mixed kinds
    for (int i = 0; i < 6; i++)
      issue(2'(i % 3), 16'(16'h9000 + i * 16'h0111), 8'(8'h30 + i), 0);

    @(negedge clk);
    while (q.size() != 0 || busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule